// File: doc/BRIEF.md
# Interrupt Dispatch and Return Unit

This unit sits next to the program sequencer of a small DSP core and decides when fetch must leave the running program for an interrupt handler. It watches a set of request lines. It evaluates them only when the core signals that an instruction has just finished. If the global enable bit of the status register is set, it takes the lowest-numbered active request and emits a one-cycle take pulse with the vector address. In the same step it pushes the return address and the current status word onto a small hardware stack. When the core retires a return-from-interrupt, the unit pops that frame. It hands the return address back to the sequencer and reloads the status register from the saved copy.

Taking an interrupt leaves the global enable untouched, so a request raised inside a handler is taken at the next instruction boundary and the handlers nest. Requests are never latched. A request that meets a cleared enable at a boundary is lost, and it is not delivered when software sets the enable again. Software clears or sets the enable through ordinary status-register writes. Because the return restores the saved status word, an enable that a handler cleared comes back on when the handler returns.

All pins are plain control strobes with no back-pressure. The core is expected to act on `take_irq` and `ret_valid` in the cycle they are high.

Top module: `dsp_irq_unit`

## Requirements
- R1: After reset the status register reads SR_RESET (default 16'h2224, enable bit 9 set), the stack depth is 0, the error flag is 0, and `take_irq` and `ret_valid` are 0.
- R2: When `insn_done` is high without `rti`, bit 9 of the status register is 1 and `irq_req` is nonzero, `take_irq` is high in the next cycle only, with `vector_pc` = VEC_BASE (default 0) + index of the lowest set request bit. The accelerator request is line 5, which gives vector 5.
- R3: Requests present while `insn_done` is low cause no dispatch and no stack change.
- R4: With bit 9 clear at a boundary, the requests are dropped: no dispatch and no stack change. Setting bit 9 again later does not deliver them.
- R5: A dispatch pushes {`next_pc`, current status} and raises the depth by one. It leaves the status register unchanged, so a request at a later boundary inside the handler nests.
- R6: A `rti` with a non-empty stack pops the newest frame. In the next cycle `ret_valid` pulses with `ret_pc` = the saved PC, the status register holds the saved status word and the depth drops by one.
- R7: A status write (`sr_wr_en`) is visible on `sr_rd_data` in the next cycle. When `rti` pops in the same cycle, the restored value wins over the write.
- R8: A dispatch while the stack holds DEPTH frames (default 4) still pulses `take_irq`. It sets the sticky `stack_err`, keeps the stored frames intact and leaves the depth at DEPTH.
- R9: A `rti` on an empty stack sets `stack_err`, gives no `ret_valid` and leaves the status register unchanged. Only reset clears `stack_err`.
- R10: When `rti` and `insn_done` are high in the same cycle, the return is performed and no request is taken at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_IRQ | Request lines, line i maps to vector slot i |
| insn_done | input | 1 | Instruction-boundary strobe |
| next_pc | input | 16 | Address of the next instruction, saved on dispatch |
| rti | input | 1 | Return-from-interrupt retired |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_data | input | 16 | Status register write value |
| sr_rd_data | output | 16 | Current status register |
| take_irq | output | 1 | One-cycle dispatch pulse |
| vector_pc | output | 16 | Handler slot address, valid with take_irq |
| ret_valid | output | 1 | One-cycle return pulse |
| ret_pc | output | 16 | Restored return address, valid with ret_valid |
| stack_depth | output | CNT_W | Frames currently stacked |
| stack_err | output | 1 | Sticky overflow/underflow flag |

## Verification
A corrupted stack pointer or frame shows up at the first return after it: `ret_pc` or the restored status word differs from what was pushed, and `stack_depth` moves off its count one cycle after the offending strobe. A wrong enable decision, such as a latched request or a masked request let through, appears as a stray or missing `take_irq` in the cycle after the boundary. A priority error shows in the `vector_pc` sampled with that same pulse. The bench therefore checks every request pattern and samples the outputs exactly one cycle after each strobe.

// File: rtl/dsp_irq_pkg.sv
package dsp_irq_pkg;
  localparam int PC_W = 16;
  localparam int SR_W = 16;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [SR_W-1:0] sr;
  } irq_frame_t;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] req,
  input  logic             en,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic [N_IRQ-1:0] grant
);
  // lowest index has highest priority: scan from the top down
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = '0;
        grant[i] = 1'b1;
      end
    end
    if (!en) grant = '0;
    hit = en && (req != '0);
  end

  // R2: at most one grant, only to a requesting line
  always_comb begin
    if (en) begin
      p_grant_onehot_r2: assert ($onehot0(grant) && ((grant & ~req) == '0));
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack
  import dsp_irq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  irq_frame_t       din,
  output irq_frame_t       top,
  output logic             empty,
  output logic [CNT_W-1:0] cnt,
  output logic             err
);
  irq_frame_t       mem [DEPTH];
  logic             full;
  logic [CNT_W-1:0] top_ptr;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign top_ptr = cnt - CNT_W'(1);
  assign top     = mem[top_ptr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else if (push) begin
      if (full) begin
        err <= 1'b1;
      end else begin
        mem[cnt[IDX_W-1:0]] <= din;
        cnt <= cnt + CNT_W'(1);
      end
    end else if (pop) begin
      if (empty) err <= 1'b1;
      else       cnt <= cnt - CNT_W'(1);
    end
  end

  // R8: the pointer never passes the capacity
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R9: the error flag holds once set
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import dsp_irq_pkg::*;
#(
  parameter logic [SR_W-1:0] SR_RESET = 16'h2224
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SR_W-1:0] wr_data,
  input  logic            restore_en,
  input  logic [SR_W-1:0] restore_data,
  output logic [SR_W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (!rst_n)          sr <= SR_RESET;
    else if (restore_en) sr <= restore_data;
    else if (wr_en)      sr <= wr_data;
  end

  // R7: a restore always beats a concurrent write
  p_restore_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> sr == $past(restore_data));
endmodule

// File: rtl/dsp_irq_unit.sv
module dsp_irq_unit
  import dsp_irq_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DEPTH = 4,
  parameter int IE_BIT = 9,
  parameter logic [PC_W-1:0] VEC_BASE = 16'h0000,
  parameter logic [SR_W-1:0] SR_RESET = 16'h2224,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             insn_done,
  input  logic [PC_W-1:0]  next_pc,
  input  logic             rti,
  input  logic             sr_wr_en,
  input  logic [SR_W-1:0]  sr_wr_data,
  output logic [SR_W-1:0]  sr_rd_data,
  output logic             take_irq,
  output logic [PC_W-1:0]  vector_pc,
  output logic             ret_valid,
  output logic [PC_W-1:0]  ret_pc,
  output logic [CNT_W-1:0] stack_depth,
  output logic             stack_err
);
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic [SR_W-1:0]  sr_q;
  logic             arb_hit;
  logic [IDX_W-1:0] arb_idx;
  logic [N_IRQ-1:0] arb_grant;
  logic             boundary;
  logic             do_take;
  logic             do_pop;
  logic             stk_empty;
  irq_frame_t       push_frame;
  irq_frame_t       top_frame;

  // a retiring return owns its boundary: no dispatch there
  assign boundary = insn_done && !rti;

  irq_prio_arb #(.N_IRQ(N_IRQ)) u_arb (
    .req   (irq_req),
    .en    (boundary && sr_q[IE_BIT]),
    .hit   (arb_hit),
    .idx   (arb_idx),
    .grant (arb_grant)
  );

  assign do_take    = arb_hit;
  assign do_pop     = rti && !stk_empty;
  assign push_frame = '{pc: next_pc, sr: sr_q};

  irq_ret_stack #(.DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (do_take),
    .pop   (rti),
    .din   (push_frame),
    .top   (top_frame),
    .empty (stk_empty),
    .cnt   (stack_depth),
    .err   (stack_err)
  );

  irq_status_reg #(.SR_RESET(SR_RESET)) u_sr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (sr_wr_en),
    .wr_data      (sr_wr_data),
    .restore_en   (do_pop),
    .restore_data (top_frame.sr),
    .sr           (sr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_irq  <= 1'b0;
      vector_pc <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
    end else begin
      take_irq  <= do_take;
      ret_valid <= do_pop;
      if (do_take) vector_pc <= VEC_BASE + PC_W'(arb_idx);
      if (do_pop)  ret_pc    <= top_frame.pc;
    end
  end

  assign sr_rd_data = sr_q;

  // R3: a dispatch only follows an instruction boundary
  p_take_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(insn_done) && !$past(rti));
  // R4: a dispatch only follows an enabled status word
  p_take_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(sr_q[IE_BIT]));
  // R5: dispatch alone leaves the status word as it was
  p_take_keeps_sr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !$past(sr_wr_en)) |-> $stable(sr_q));
  // R6: a return pulse only follows a return strobe
  p_ret_after_rti_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(rti));
  // R10: return and dispatch never share a cycle
  p_no_take_with_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_irq && ret_valid));
endmodule

// File: tb/dsp_irq_unit_bench.sv
`timescale 1ns/1ps
module dsp_irq_unit_bench;
  localparam int N_IRQ = 8;
  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [15:0] SR_ON  = 16'h2224;
  localparam logic [15:0] SR_OFF = 16'h2024;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_IRQ-1:0] irq_req = '0;
  logic             insn_done = 1'b0;
  logic [15:0]      next_pc = '0;
  logic             rti = 1'b0;
  logic             sr_wr_en = 1'b0;
  logic [15:0]      sr_wr_data = '0;
  logic [15:0]      sr_rd_data;
  logic             take_irq;
  logic [15:0]      vector_pc;
  logic             ret_valid;
  logic [15:0]      ret_pc;
  logic [CNT_W-1:0] stack_depth;
  logic             stack_err;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dsp_irq_unit u_dsp_irq_unit (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
    .next_pc(next_pc), .rti(rti), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .sr_rd_data(sr_rd_data), .take_irq(take_irq), .vector_pc(vector_pc),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .stack_depth(stack_depth),
    .stack_err(stack_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then sample after the edge
  task automatic step(input logic [N_IRQ-1:0] rq, input logic done, input logic [15:0] pc,
                      input logic r, input logic we, input logic [15:0] wd);
    @(negedge clk);
    irq_req = rq; insn_done = done; next_pc = pc; rti = r; sr_wr_en = we; sr_wr_data = wd;
    @(negedge clk);
    irq_req = '0; insn_done = 1'b0; rti = 1'b0; sr_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int lowest(input logic [N_IRQ-1:0] p);
    int e = -1;
    for (int i = N_IRQ - 1; i >= 0; i--) if (p[i]) e = i;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 sr", sr_rd_data, SR_ON);
    check("R1 depth", stack_depth, 0);
    check("R1 err", stack_err, 0);
    check("R1 take", take_irq, 0);
    check("R1 ret", ret_valid, 0);

    // R3: requests away from a boundary
    step('1, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
    check("R3 take", take_irq, 0);
    check("R3 depth", stack_depth, 0);

    // R2 R5 R6: every request pattern, enter then return
    for (int p = 0; p < (1 << N_IRQ); p++) begin
      step(N_IRQ'(p), 1'b1, 16'h0100 + 16'(p), 1'b0, 1'b0, 16'h0);
      if (p == 0) begin
        check("R2 idle take", take_irq, 0);
        check("R2 idle depth", stack_depth, 0);
      end else begin
        check("R2 take", take_irq, 1);
        check("R2 vector", vector_pc, 32'(lowest(N_IRQ'(p))));
        check("R5 depth", stack_depth, 1);
        check("R5 sr kept", sr_rd_data, SR_ON);
        step('0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
        check("R2 pulse width", take_irq, 0);
        step('0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
        check("R6 ret_valid", ret_valid, 1);
        check("R6 ret_pc", ret_pc, 16'h0100 + 16'(p));
        check("R6 depth", stack_depth, 0);
        check("R6 sr", sr_rd_data, SR_ON);
      end
    end

    // R4: masked requests are dropped and not delivered later
    step('0, 1'b0, 16'h0, 1'b0, 1'b1, SR_OFF);
    check("R7 write", sr_rd_data, SR_OFF);
    for (int p = 1; p < (1 << N_IRQ); p++) begin
      step(N_IRQ'(p), 1'b1, 16'h0200, 1'b0, 1'b0, 16'h0);
      check("R4 masked take", take_irq, 0);
      check("R4 masked depth", stack_depth, 0);
    end
    step('0, 1'b0, 16'h0, 1'b0, 1'b1, SR_ON);
    step('0, 1'b1, 16'h0210, 1'b0, 1'b0, 16'h0);
    check("R4 no late take", take_irq, 0);
    check("R4 no late depth", stack_depth, 0);

    // R5: nesting, then a handler that masks and re-enables
    step(8'h20, 1'b1, 16'h0010, 1'b0, 1'b0, 16'h0);
    check("R2 accel vector", vector_pc, 5);
    step(8'h20, 1'b1, 16'h0020, 1'b0, 1'b0, 16'h0);
    check("R5 nested take", take_irq, 1);
    check("R5 nested depth", stack_depth, 2);
    step('0, 1'b0, 16'h0, 1'b0, 1'b1, 16'h2020);
    step(8'h01, 1'b1, 16'h0030, 1'b0, 1'b0, 16'h0);
    check("R4 in-handler masked", take_irq, 0);
    step('0, 1'b0, 16'h0, 1'b0, 1'b1, 16'h2220);
    step('0, 1'b1, 16'h0031, 1'b0, 1'b0, 16'h0);
    check("R4 in-handler no late", take_irq, 0);
    check("R4 in-handler depth", stack_depth, 2);
    step('0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    check("R6 inner ret_pc", ret_pc, 16'h0020);
    check("R6 inner sr", sr_rd_data, SR_ON);
    check("R6 inner depth", stack_depth, 1);
    step('0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    check("R6 outer ret_pc", ret_pc, 16'h0010);
    check("R6 outer depth", stack_depth, 0);

    // R10: return and boundary together
    step(8'h01, 1'b1, 16'h0050, 1'b0, 1'b0, 16'h0);
    step(8'h01, 1'b1, 16'h0060, 1'b1, 1'b0, 16'h0);
    check("R10 ret", ret_valid, 1);
    check("R10 take", take_irq, 0);
    check("R10 depth", stack_depth, 0);

    // R7: restore beats a write in the same cycle
    step('0, 1'b0, 16'h0, 1'b0, 1'b1, 16'h2a24);
    step(8'h02, 1'b1, 16'h0070, 1'b0, 1'b0, 16'h0);
    check("R2 vector 1", vector_pc, 1);
    step('0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h1234);
    check("R7 restore wins", sr_rd_data, 16'h2a24);
    step('0, 1'b0, 16'h0, 1'b0, 1'b1, SR_ON);
    check("R7 write back", sr_rd_data, SR_ON);

    // R8: overflow
    for (int i = 0; i < DEPTH; i++) step(8'h80, 1'b1, 16'h0040 + 16'(i), 1'b0, 1'b0, 16'h0);
    check("R8 full depth", stack_depth, DEPTH);
    check("R8 no err yet", stack_err, 0);
    step(8'h80, 1'b1, 16'h00ff, 1'b0, 1'b0, 16'h0);
    check("R8 take on full", take_irq, 1);
    check("R8 vector", vector_pc, 7);
    check("R8 err", stack_err, 1);
    check("R8 depth held", stack_depth, DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      step('0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
      check("R8 frame intact", ret_pc, 16'h0040 + 16'(i));
    end
    check("R9 err sticky", stack_err, 1);

    // R9: underflow
    do_reset();
    check("R1 err after reset", stack_err, 0);
    step('0, 1'b0, 16'h0, 1'b0, 1'b1, 16'h2000);
    step('0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
    check("R9 no ret", ret_valid, 0);
    check("R9 err", stack_err, 1);
    check("R9 sr", sr_rd_data, 16'h2000);
    check("R9 depth", stack_depth, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule